// File: doc/BRIEF.md
# Shadow-Backed Static Memory with Block Save and Restore

This block models a 2048 x 8 static memory in which every word has a nonvolatile twin held in a separate shadow array. The front side acts like an ordinary asynchronous SRAM, sampled on a clock. It has active-low chip select, output enable and write enable, an 11-bit address, a write data bus, a registered read data bus and a flag that says when that bus is being driven. A power-good input tells the block when supply is lost and when it comes back.

On loss of power, the block saves the working array into the shadow array. On restoration, it restores the working array from the shadow array. The restore first wipes the working array and then copies the shadow data back. Firmware can start either transfer without a power event by issuing a fixed run of six reads. Both arrays are split into 32 rows of 64 words. A transfer moves one full row per clock. While a transfer runs, the memory port is locked out and a busy flag is raised.

Top module: `nv_shadow_sram`

## Requirements
- R1: With `ce_n`=0, `we_n`=1 and `oe_n`=0 in a cycle, the word at `addr` appears on `dout` with `dout_en`=1 one clock later.
- R2: With `ce_n`=1, nothing is written, whatever `we_n` is, and `dout_en` is 0 one clock later.
- R3: With `ce_n`=0 and `we_n`=0, `din` is written to `addr` whatever the value of `oe_n`, and `dout_en` is 0 one clock later.
- R4: With `ce_n`=0, `we_n`=1 and `oe_n`=1, the access counts as an internal read, and `dout_en` is 0 one clock later.
- R5: When `pwr_good` is seen falling while the block is idle, a save starts. The save copies every working word into its shadow word and holds `busy` high for exactly 32 cycles.
- R6: When `pwr_good` is seen rising while the block is idle, a restore starts. It holds `busy` high for 64 cycles: 32 clearing cycles followed by 32 copy cycles. Afterwards every working word equals its shadow word, and the shadow array is not modified.
- R7: Six consecutive reads at 0x000, 0x555, 0x2AA, 0x7FF, 0x0AA and then 0x0F0 start a save. The same run ending at 0x70F instead starts a restore.
- R8: A write, or a read at any address other than the next expected one, abandons the run. If that read is at 0x000, it counts as a new first step. Deselected cycles with `ce_n`=1 neither advance nor break the run.
- R9: While `busy` is high, reads and writes have no effect and `dout_en` stays 0. The read in the cycle a transfer starts does not drive `dout` either.
- R10: Power edges and trigger runs that occur while a transfer is running are ignored. When a power fall and a completed trigger run fall in the same cycle, the power event wins.
- R11: A `pwr_good` fall during a restore aborts it at once: `busy` drops on the next clock and no save starts. Rows not yet copied stay cleared.
- R12: During and right after reset, `busy` and `dout_en` are 0, and no transfer starts when reset is released, whatever the level of `pwr_good`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | 11 | Word address; bits 10:6 select the row |
| din | input | 8 | Write data |
| dout | output | 8 | Registered read data |
| dout_en | output | 1 | High when `dout` is driven (low means high impedance) |
| pwr_good | input | 1 | Supply status; a fall starts a save and a rise starts a restore |
| busy | output | 1 | High while a save or restore runs |

## Verification
A supply drop can arrive in the same clock as the sixth read of a restore trigger run. The bench provokes this by lowering `pwr_good` on the same edge at which it presents address 0x70F. It judges the outcome in two ways. First, the busy window must last 32 cycles, which is a save, rather than 64. Second, after a later restore, a word changed just before the collision must return with its changed value. That can only happen if the collision saved the working array rather than restoring over it.

// File: rtl/nv_shadow_sram.sv
module nv_shadow_sram #(
  parameter int ROWS = 32,
  parameter int COLS = 64,
  parameter int DW   = 8,
  localparam int WORDS = ROWS * COLS,
  localparam int AW    = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          we_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout,
  output logic          dout_en,
  input  logic          pwr_good,
  output logic          busy
);
  localparam int RW = $clog2(ROWS);
  localparam logic [AW-1:0] K0 = AW'(11'h000);
  localparam logic [AW-1:0] K1 = AW'(11'h555);
  localparam logic [AW-1:0] K2 = AW'(11'h2AA);
  localparam logic [AW-1:0] K3 = AW'(11'h7FF);
  localparam logic [AW-1:0] K4 = AW'(11'h0AA);
  localparam logic [AW-1:0] K_SAVE = AW'(11'h0F0);
  localparam logic [AW-1:0] K_REST = AW'(11'h70F);

  typedef enum logic [1:0] {IDLE, SAVE, WIPE, LOAD} mode_t;

  mode_t         mode, mode_nx;
  logic [RW-1:0] row, row_nx;
  logic          pg_q;
  logic [2:0]    step;
  logic [DW-1:0] work   [WORDS];
  logic [DW-1:0] shadow [WORDS];
  logic [DW-1:0] dout_q;
  logic          dout_en_q;

  logic rd_ok, wr_ok, pg_rise, pg_fall, sw_save, sw_rest, last_row, go;

  function automatic logic [AW-1:0] step_addr(input logic [2:0] s);
    case (s)
      3'd0:    return K0;
      3'd1:    return K1;
      3'd2:    return K2;
      3'd3:    return K3;
      default: return K4;
    endcase
  endfunction

  assign busy     = (mode != IDLE);
  assign rd_ok    = rst_n && !ce_n && we_n && !busy;
  assign wr_ok    = rst_n && !ce_n && !we_n && !busy;
  assign pg_rise  = pwr_good && !pg_q;
  assign pg_fall  = !pwr_good && pg_q;
  assign sw_save  = rd_ok && (step == 3'd5) && (addr == K_SAVE);
  assign sw_rest  = rd_ok && (step == 3'd5) && (addr == K_REST);
  assign last_row = (row == RW'(ROWS - 1));
  assign go       = (mode == IDLE) && (mode_nx != IDLE);
  assign dout     = dout_q;
  assign dout_en  = dout_en_q;

  always_comb begin
    mode_nx = mode;
    row_nx  = row;
    unique case (mode)
      IDLE: begin
        row_nx = '0;
        if (pg_fall)      mode_nx = SAVE;
        else if (pg_rise) mode_nx = WIPE;
        else if (sw_save) mode_nx = SAVE;
        else if (sw_rest) mode_nx = WIPE;
      end
      SAVE: begin
        row_nx = last_row ? '0 : row + 1'b1;
        if (last_row) mode_nx = IDLE;
      end
      WIPE: begin
        if (pg_fall) begin
          mode_nx = IDLE;
          row_nx  = '0;
        end else begin
          row_nx = last_row ? '0 : row + 1'b1;
          if (last_row) mode_nx = LOAD;
        end
      end
      LOAD: begin
        if (pg_fall || last_row) begin
          mode_nx = IDLE;
          row_nx  = '0;
        end else begin
          row_nx = row + 1'b1;
        end
      end
      default: mode_nx = IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode      <= IDLE;
      row       <= '0;
      pg_q      <= pwr_good;
      step      <= '0;
      dout_q    <= '0;
      dout_en_q <= 1'b0;
    end else begin
      mode      <= mode_nx;
      row       <= row_nx;
      pg_q      <= pwr_good;
      dout_en_q <= rd_ok && !oe_n && !go;
      if (rd_ok) dout_q <= work[addr];
      if (go || wr_ok) begin
        step <= '0;
      end else if (rd_ok) begin
        if (step < 3'd5 && addr == step_addr(step)) step <= step + 3'd1;
        else if (addr == K0)                        step <= 3'd1;
        else                                        step <= 3'd0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wr_ok) work[addr] <= din;
    if (mode == WIPE && !pg_fall)
      for (int c = 0; c < COLS; c++) work[AW'(int'(row) * COLS + c)] <= '0;
    if (mode == LOAD && !pg_fall)
      for (int c = 0; c < COLS; c++)
        work[AW'(int'(row) * COLS + c)] <= shadow[AW'(int'(row) * COLS + c)];
  end

  always_ff @(posedge clk) begin
    if (mode == SAVE)
      for (int c = 0; c < COLS; c++)
        shadow[AW'(int'(row) * COLS + c)] <= work[AW'(int'(row) * COLS + c)];
  end
endmodule

// File: rtl/nv_shadow_sram_chk.sv
module nv_shadow_sram_chk #(
  parameter int ROWS = 32
) (
  input logic clk,
  input logic rst_n,
  input logic ce_n,
  input logic oe_n,
  input logic we_n,
  input logic pwr_good,
  input logic dout_en,
  input logic busy
);
  logic [15:0] run;

  always_ff @(posedge clk) begin
    if (!rst_n)    run <= '0;
    else if (busy) run <= run + 16'd1;
    else           run <= '0;
  end

  a_r2_deselect_hiz: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |=> !dout_en);
  a_r3_write_hiz: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && !we_n) |=> !dout_en);
  a_r4_internal_read_hiz: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && we_n && oe_n) |=> !dout_en);
  a_r9_locked_hiz: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !dout_en);
  a_r5_fall_starts: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(pwr_good) && !busy) |=> busy);
  a_r6_rise_starts: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(pwr_good) && !busy) |=> busy);
  a_r6_busy_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    run <= 16'(2 * ROWS));
endmodule

bind nv_shadow_sram nv_shadow_sram_chk #(.ROWS(ROWS)) u_chk (
  .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
  .pwr_good(pwr_good), .dout_en(dout_en), .busy(busy)
);

// File: tb/test_nv_shadow_sram.sv
module test_nv_shadow_sram;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, pwr_good = 1'b1;
  logic [10:0] addr = '0;
  logic [7:0]  din = '0, dout;
  logic dout_en, busy;
  int errors = 0, checks = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  nv_shadow_sram i_nv_shadow_sram (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .din(din), .dout(dout), .dout_en(dout_en),
    .pwr_good(pwr_good), .busy(busy)
  );

  typedef struct packed {
    logic ce, we, oe;
    logic [10:0] a;
    logic [7:0] d;
    logic en;
    logic [7:0] q;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t TBL [NV] = '{
    '{1'b0, 1'b0, 1'b0, 11'h123, 8'h5A, 1'b0, 8'h00, 4'd3},  // R3 write, oe low
    '{1'b0, 1'b0, 1'b1, 11'h456, 8'hC3, 1'b0, 8'h00, 4'd3},  // R3 write, oe high
    '{1'b0, 1'b1, 1'b0, 11'h123, 8'h00, 1'b1, 8'h5A, 4'd1},  // R1
    '{1'b0, 1'b1, 1'b0, 11'h456, 8'h00, 1'b1, 8'hC3, 4'd1},  // R1
    '{1'b0, 1'b1, 1'b1, 11'h123, 8'h00, 1'b0, 8'h00, 4'd4},  // R4
    '{1'b1, 1'b0, 1'b0, 11'h123, 8'hFF, 1'b0, 8'h00, 4'd2},  // R2 deselected write
    '{1'b0, 1'b1, 1'b0, 11'h123, 8'h00, 1'b1, 8'h5A, 4'd2},  // R2 word intact
    '{1'b0, 1'b0, 1'b0, 11'h7FF, 8'h81, 1'b0, 8'h00, 4'd3},  // R3
    '{1'b0, 1'b1, 1'b0, 11'h7FF, 8'h00, 1'b1, 8'h81, 4'd1},  // R1
    '{1'b0, 1'b0, 1'b1, 11'h000, 8'h3C, 1'b0, 8'h00, 4'd3},  // R3
    '{1'b0, 1'b1, 1'b0, 11'h000, 8'h00, 1'b1, 8'h3C, 4'd1}   // R1
  };

  function automatic logic [7:0] pat(input int a);
    return 8'(a * 37 + 1);
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic c, input logic w, input logic o,
                     input logic [10:0] a, input logic [7:0] d);
    ce_n = c; we_n = w; oe_n = o; addr = a; din = d;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
    repeat (n) @(negedge clk);
  endtask

  task automatic rd(input logic [10:0] a, input logic [7:0] exp, input string tag);
    cyc(1'b0, 1'b1, 1'b0, a, 8'h00);
    chk({tag, " dout_en"}, int'(dout_en), 1);
    chk({tag, " dout"}, int'(dout), int'(exp));
  endtask

  task automatic wr(input logic [10:0] a, input logic [7:0] d);
    cyc(1'b0, 1'b0, 1'b1, a, d);
  endtask

  task automatic run_len(output int n);
    ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
    n = 0;
    while (busy && n < 300) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic prefix();
    cyc(1'b0, 1'b1, 1'b1, 11'h000, 8'h00);
    cyc(1'b0, 1'b1, 1'b1, 11'h555, 8'h00);
    cyc(1'b0, 1'b1, 1'b1, 11'h2AA, 8'h00);
    cyc(1'b0, 1'b1, 1'b1, 11'h7FF, 8'h00);
    cyc(1'b0, 1'b1, 1'b1, 11'h0AA, 8'h00);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    chk("R12 busy in reset", int'(busy), 0);
    chk("R12 dout_en in reset", int'(dout_en), 0);
    rst_n = 1'b1;
    idle(3);
    chk("R12 no transfer after release", int'(busy), 0);

    for (int i = 0; i < NV; i++) begin
      cyc(TBL[i].ce, TBL[i].we, TBL[i].oe, TBL[i].a, TBL[i].d);
      chk($sformatf("R%0d vector %0d dout_en", TBL[i].req, i), int'(dout_en), int'(TBL[i].en));
      if (TBL[i].en)
        chk($sformatf("R%0d vector %0d dout", TBL[i].req, i), int'(dout), int'(TBL[i].q));
    end

    for (int a = 0; a < 2048; a++) wr(11'(a), pat(a));

    // R7 save by trigger run; R9 trigger read does not drive
    prefix();
    cyc(1'b0, 1'b1, 1'b0, 11'h0F0, 8'h00);
    chk("R9 trigger read dout_en", int'(dout_en), 0);
    run_len(n);
    chk("R7 save run length", n, 32);

    wr(11'h010, 8'hEE);
    wr(11'h7F0, 8'hEE);
    // R7 restore by trigger run, R9 lockout during it
    prefix();
    cyc(1'b0, 1'b1, 1'b0, 11'h70F, 8'h00);
    chk("R7 restore started", int'(busy), 1);
    cyc(1'b0, 1'b0, 1'b0, 11'h020, 8'h00);
    cyc(1'b0, 1'b1, 1'b0, 11'h020, 8'h00);
    chk("R9 read while busy dout_en", int'(dout_en), 0);
    run_len(n);
    chk("R6 restore run length", n + 2, 64);
    rd(11'h010, pat(16'h010), "R6 restored word");
    rd(11'h7F0, pat(16'h7F0), "R6 restored word");
    rd(11'h020, pat(16'h020), "R9 write while busy ignored");

    // R8 broken runs
    cyc(1'b0, 1'b1, 1'b1, 11'h000, 8'h00);
    cyc(1'b0, 1'b1, 1'b1, 11'h555, 8'h00);
    cyc(1'b0, 1'b1, 1'b1, 11'h2AA, 8'h00);
    wr(11'h300, pat(16'h300));
    cyc(1'b0, 1'b1, 1'b1, 11'h7FF, 8'h00);
    cyc(1'b0, 1'b1, 1'b1, 11'h0AA, 8'h00);
    cyc(1'b0, 1'b1, 1'b1, 11'h0F0, 8'h00);
    idle(1);
    chk("R8 write breaks run", int'(busy), 0);
    cyc(1'b0, 1'b1, 1'b1, 11'h000, 8'h00);
    cyc(1'b0, 1'b1, 1'b1, 11'h555, 8'h00);
    cyc(1'b0, 1'b1, 1'b1, 11'h123, 8'h00);
    cyc(1'b0, 1'b1, 1'b1, 11'h2AA, 8'h00);
    cyc(1'b0, 1'b1, 1'b1, 11'h7FF, 8'h00);
    cyc(1'b0, 1'b1, 1'b1, 11'h0AA, 8'h00);
    cyc(1'b0, 1'b1, 1'b1, 11'h0F0, 8'h00);
    idle(1);
    chk("R8 stray read breaks run", int'(busy), 0);
    prefix();
    cyc(1'b0, 1'b1, 1'b1, 11'h123, 8'h00);
    idle(1);
    chk("R8 wrong final address", int'(busy), 0);
    cyc(1'b0, 1'b1, 1'b1, 11'h000, 8'h00);
    cyc(1'b0, 1'b1, 1'b1, 11'h555, 8'h00);
    prefix();
    cyc(1'b0, 1'b1, 1'b1, 11'h0F0, 8'h00);
    run_len(n);
    chk("R8 restart at first address", n, 32);
    cyc(1'b0, 1'b1, 1'b1, 11'h000, 8'h00);
    idle(2);
    cyc(1'b0, 1'b1, 1'b1, 11'h555, 8'h00);
    idle(1);
    cyc(1'b0, 1'b1, 1'b1, 11'h2AA, 8'h00);
    cyc(1'b0, 1'b1, 1'b1, 11'h7FF, 8'h00);
    cyc(1'b0, 1'b1, 1'b1, 11'h0AA, 8'h00);
    cyc(1'b0, 1'b1, 1'b1, 11'h0F0, 8'h00);
    run_len(n);
    chk("R8 deselected cycles tolerated", n, 32);

    // R5 power-fall save, R6 power-rise restore
    wr(11'h040, 8'h77);
    ce_n = 1'b1; pwr_good = 1'b0;
    @(negedge clk);
    run_len(n);
    chk("R5 save run length", n, 32);
    wr(11'h040, 8'h11);
    pwr_good = 1'b1;
    @(negedge clk);
    run_len(n);
    chk("R6 power restore run length", n, 64);
    rd(11'h040, 8'h77, "R6 saved word back");
    rd(11'h041, pat(16'h041), "R6 neighbour word");

    // R10 rise during save ignored
    pwr_good = 1'b0;
    @(negedge clk);
    repeat (4) @(negedge clk);
    pwr_good = 1'b1;
    run_len(n);
    chk("R10 save unaffected by rise", n + 4, 32);
    idle(3);
    chk("R10 no restore after save", int'(busy), 0);

    // R10 power fall and restore trigger in the same cycle
    wr(11'h050, 8'h99);
    prefix();
    pwr_good = 1'b0;
    cyc(1'b0, 1'b1, 1'b1, 11'h70F, 8'h00);
    run_len(n);
    chk("R10 power wins over trigger", n, 32);
    pwr_good = 1'b1;
    @(negedge clk);
    run_len(n);
    rd(11'h050, 8'h99, "R10 collision saved working data");

    // R11 abort restore during copy phase
    pwr_good = 1'b0;
    @(negedge clk);
    run_len(n);
    pwr_good = 1'b1;
    @(negedge clk);
    repeat (40) @(negedge clk);
    pwr_good = 1'b0;
    @(negedge clk);
    chk("R11 busy drops at abort", int'(busy), 0);
    idle(1);
    chk("R11 no save after abort", int'(busy), 0);
    rd(11'h080, pat(16'h080), "R11 copied row");
    rd(11'h500, 8'h00, "R11 uncopied row cleared");
    pwr_good = 1'b1;
    @(negedge clk);
    run_len(n);
    rd(11'h500, pat(16'h500), "R11 shadow intact");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule